// File: doc/BRIEF.md
# Interrupt-capable GPIO bank controller

This block is one bank of up to 32 general-purpose pins behind a flat 32-bit register file. A processor writes and reads it over a simple single-cycle register port. Each pin can work in one of three ways: as a plain input, as a plain output that drives a stored data bit, or as an interrupt source. An interrupt source senses either a level or an edge. Its polarity is selectable, and an edge source can also be set to react to both transitions.

Every pin passes through a two-flop synchroniser before any logic looks at it. Edge events are latched into a status register and stay there until software writes a one to the clear register. In level mode the status bit simply tracks the pin after polarity adjustment. A mask register gates the status bits into one combined interrupt line. Software can narrow the mask with one register and widen it with another, so neither action needs a read-modify-write. Reads are combinational from the presented address. A write takes effect at the clock edge where `we_i` is high.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is a general input (`gpio_oe_o` = 0), and the mode, direction, output data, polarity, trigger, both-edge and mask registers all read 0. The status register reads 0 and `irq_o` is low.
- R2: In general I/O mode (offset 0x00 bit = 0), `gpio_oe_o` bit equals the direction bit at offset 0x04 (1 = output). `gpio_o` always equals the output data register at 0x08. A write to 0x08 is stored and read back even while the pin is an input, so the output value can be loaded before the direction changes.
- R3: Offset 0x0C returns the pins after a two-flop synchroniser. A pin change made between clock edges is visible after the second following edge and not after the first.
- R4: A pin with mode bit 1 (0x00) and trigger bit 1 (0x24, 1 = edge, 0 = level) sets its status bit (0x10) on a rising edge when its polarity bit (0x20) is 0, and on a falling edge when that bit is 1. The status bit then holds until it is cleared.
- R5: With both-edge bit 1 (0x4C) in edge mode, a rising edge and a falling edge each set the status bit, whatever the polarity bit holds.
- R6: In level mode (mode 1, trigger 0) the status bit equals the synchronised pin XOR the polarity bit. Writes to the clear register (0x14) do not change it.
- R7: Writing 1 to a bit of 0x14 clears a latched edge status bit. Bits written 0 leave their status unchanged. An edge arriving in the same cycle as the clear wins.
- R8: A write to 0x18 disables the pins whose bits are written 0 and leaves the others unchanged. A write of 1 to a bit of 0x1C enables that pin. Reading 0x18 returns 1 for enabled pins.
- R9: `irq_o` is high exactly when the status register ANDed with the mask register is nonzero.
- R10: A pin in general I/O mode reports status 0. Taking a pin out of edge interrupt mode discards its latched status, so it stays clear when edge mode is selected again.
- R11: Offsets outside the mapped set read 0 and writes to them are ignored. This includes 0x28 and the read-only input register 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| gpio_i | input | NUM_PINS | Pin inputs, asynchronous |
| gpio_o | output | NUM_PINS | Pin output values |
| gpio_oe_o | output | NUM_PINS | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench checks the synchroniser delay by reading the input register after one edge and again after two. A design with one flop too few or too many gives the new value too early or too late. It tests polarity on two neighbouring edge pins and tests both-edge on a third, so swapped rise and fall logic sets the wrong status bit. It confirms that clear writes leave a level-mode bit untouched and that writing zeros to the clear register changes nothing. It also checks that a pin taken out of edge mode and put back does not bring back a stale event. Mask narrowing and widening are exercised separately: a design that loads the mask register directly instead of ANDing or ORing it would re-enable or drop pins, and the interrupt line would show it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DOUT   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIN    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_UNMASK = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_POL    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_TRIG   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h4C;

  typedef struct packed {
    logic irq_en;  // 1: interrupt input
    logic edge_en; // 1: edge, 0: level
    logic pol;     // 1: active low / falling
    logic both;    // 1: both edges
  } pin_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_bank_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pin_cfg_t cfg_i,
  input  logic     lvl_i,
  input  logic     clr_i,
  output logic     stat_o
);
  logic prev_q, lat_q;
  logic edge_mode, level_mode, rise, fall, ev;

  assign edge_mode  = cfg_i.irq_en & cfg_i.edge_en;
  assign level_mode = cfg_i.irq_en & ~cfg_i.edge_en;
  assign rise       = lvl_i & ~prev_q;
  assign fall       = ~lvl_i & prev_q;
  assign ev         = cfg_i.both ? (rise | fall) : (cfg_i.pol ? fall : rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (!edge_mode)  lat_q <= 1'b0;
      else if (ev)     lat_q <= 1'b1; // event beats clear
      else if (clr_i)  lat_q <= 1'b0;
    end
  end

  assign stat_o = edge_mode ? lat_q : (level_mode & (lvl_i ^ cfg_i.pol));

  AST_LAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && edge_mode && !clr_i) |=> lat_q); // R4
  AST_CLR_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && clr_i && !ev) |=> !lat_q); // R7
  AST_IO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.irq_en) |=> !lat_q); // R10
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] gpio_i,
  output logic [NUM_PINS-1:0] gpio_o,
  output logic [NUM_PINS-1:0] gpio_oe_o,
  output logic                irq_o
);
  localparam int unsigned N = NUM_PINS;

  logic [N-1:0] mode_q, dir_q, dout_q, pol_q, trig_q, both_q, mask_q;
  logic [N-1:0] din, stat, clr_vec, wd;
  logic wr_mask, wr_unmask;

  assign wd        = wdata_i[N-1:0];
  assign wr_mask   = we_i && (addr_i == OFS_MASK);
  assign wr_unmask = we_i && (addr_i == OFS_UNMASK);
  assign clr_vec   = (we_i && (addr_i == OFS_CLR)) ? wd : '0;

  gpio_sync #(.WIDTH(N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (din)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    pin_cfg_t cfg;
    assign cfg = '{irq_en: mode_q[i], edge_en: trig_q[i], pol: pol_q[i], both: both_q[i]};
    gpio_irq_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cfg_i (cfg),
      .lvl_i (din[i]),
      .clr_i (clr_vec[i]),
      .stat_o(stat[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      both_q <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_MODE:   mode_q <= wd;
        OFS_DIR:    dir_q  <= wd;
        OFS_DOUT:   dout_q <= wd;
        OFS_POL:    pol_q  <= wd;
        OFS_TRIG:   trig_q <= wd;
        OFS_BOTH:   both_q <= wd;
        OFS_MASK:   mask_q <= mask_q & wd;
        OFS_UNMASK: mask_q <= mask_q | wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_MODE: rdata_o[N-1:0] = mode_q;
      OFS_DIR:  rdata_o[N-1:0] = dir_q;
      OFS_DOUT: rdata_o[N-1:0] = dout_q;
      OFS_DIN:  rdata_o[N-1:0] = din;
      OFS_STAT: rdata_o[N-1:0] = stat;
      OFS_MASK: rdata_o[N-1:0] = mask_q;
      OFS_POL:  rdata_o[N-1:0] = pol_q;
      OFS_TRIG: rdata_o[N-1:0] = trig_q;
      OFS_BOTH: rdata_o[N-1:0] = both_q;
      default:  rdata_o = '0;
    endcase
  end

  assign gpio_o    = dout_q;
  assign gpio_oe_o = dir_q & ~mode_q;
  assign irq_o     = |(stat & mask_q);

  AST_MASK_NO_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> ((mask_q & ~$past(mask_q)) == '0)); // R8
  AST_UNMASK_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_unmask |=> (($past(wd) & ~mask_q) == '0)); // R8
  AST_MASK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_mask && !wr_unmask) |=> $stable(mask_q)); // R8
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0)); // R9
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  localparam int NP = 32;
  localparam logic [7:0] A_MODE = 8'h00, A_DIR = 8'h04, A_DOUT = 8'h08, A_DIN = 8'h0C,
    A_STAT = 8'h10, A_CLR = 8'h14, A_MASK = 8'h18, A_UNM = 8'h1C, A_POL = 8'h20,
    A_TRIG = 8'h24, A_FILT = 8'h28, A_BOTH = 8'h4C;

  logic clk = 0, rst_n = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NP-1:0] pins = 0, gout, goe;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_bank #(.NUM_PINS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .gpio_i(pins), .gpio_o(gout), .gpio_oe_o(goe), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_s1, m_s2, m_prev, m_lat, m_mode, m_dir, m_dout, m_pol, m_trig, m_both, m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_lat <= 0; m_mode <= 0; m_dir <= 0;
      m_dout <= 0; m_pol <= 0; m_trig <= 0; m_both <= 0; m_mask <= 0;
    end else begin
      logic [31:0] nl;
      nl = m_lat;
      for (int i = 0; i < NP; i++) begin
        bit r, f, e;
        r = m_s2[i] && !m_prev[i];
        f = !m_s2[i] && m_prev[i];
        e = m_both[i] ? (r || f) : (m_pol[i] ? f : r);
        if (!(m_mode[i] && m_trig[i])) nl[i] = 0;
        else if (e) nl[i] = 1;
        else if (we && addr == A_CLR && wdata[i]) nl[i] = 0;
      end
      m_lat <= nl;
      m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
      if (we) begin
        if (addr == A_MODE) m_mode <= wdata;
        if (addr == A_DIR)  m_dir  <= wdata;
        if (addr == A_DOUT) m_dout <= wdata;
        if (addr == A_POL)  m_pol  <= wdata;
        if (addr == A_TRIG) m_trig <= wdata;
        if (addr == A_BOTH) m_both <= wdata;
        if (addr == A_MASK) m_mask <= m_mask & wdata;
        if (addr == A_UNM)  m_mask <= m_mask | wdata;
      end
    end
  end

  function automatic logic [31:0] m_stat();
    logic [31:0] s = 0;
    for (int i = 0; i < NP; i++) begin
      if (m_mode[i] && m_trig[i]) s[i] = m_lat[i];
      else if (m_mode[i]) s[i] = m_s2[i] ^ m_pol[i];
    end
    return s;
  endfunction

  function automatic logic [31:0] m_rd(input logic [7:0] a);
    case (a)
      A_MODE: return m_mode;
      A_DIR:  return m_dir;
      A_DOUT: return m_dout;
      A_DIN:  return m_s2;
      A_STAT: return m_stat();
      A_MASK: return m_mask;
      A_POL:  return m_pol;
      A_TRIG: return m_trig;
      A_BOTH: return m_both;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      check("R2 gpio_o model", gout, m_dout);
      check("R2 gpio_oe_o model", goe, m_dir & ~m_mode);
      check("R9 irq_o model", {31'b0, irq}, {31'b0, |(m_stat() & m_mask)});
      check("R11 rdata model", rdata, m_rd(addr));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #3; v = rdata;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick(3); rst_n = 1; tick(1);
    // R1 reset state
    rd(A_DIR, v);  check("R1 dir", v, 0);
    rd(A_MASK, v); check("R1 mask", v, 0);
    rd(A_STAT, v); check("R1 stat", v, 0);
    rd(A_MODE, v); check("R1 mode", v, 0);
    check("R1 oe", goe, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 preload then switch direction
    wr(A_DOUT, 32'hA5A5_0F0F);
    check("R2 preload gpio_o", gout, 32'hA5A5_0F0F);
    check("R2 still input", goe, 0);
    wr(A_DIR, 32'h0000_FFFF);
    check("R2 oe follows dir", goe, 32'h0000_FFFF);
    rd(A_DOUT, v); check("R2 dout readback", v, 32'hA5A5_0F0F);

    // R3 two-flop delay
    @(negedge clk); pins = 32'h1234_5678;
    @(negedge clk); rd(A_DIN, v); check("R3 after one edge", v, 0);
    @(negedge clk); rd(A_DIN, v); check("R3 after two edges", v, 32'h1234_5678);

    // R4 edge polarity: pin0 rising, pin1 falling
    @(negedge clk); pins = 0; tick(4);
    wr(A_POL, 32'h2); wr(A_TRIG, 32'h3); wr(A_MODE, 32'h3);
    check("R2 irq pins drop oe", goe, 32'h0000_FFFC);
    @(negedge clk); pins = 32'h3; tick(4);
    rd(A_STAT, v); check("R4 rising sets pin0 only", v, 32'h1);
    @(negedge clk); pins = 32'h0; tick(4);
    rd(A_STAT, v); check("R4 falling sets pin1, pin0 holds", v, 32'h3);

    // R8/R9 mask
    check("R9 masked no irq", {31'b0, irq}, 0);
    wr(A_UNM, 32'h2);
    check("R9 unmask pin1 irq", {31'b0, irq}, 1);
    rd(A_MASK, v); check("R8 mask read", v, 32'h2);
    wr(A_UNM, 32'h1);
    rd(A_MASK, v); check("R8 unmask keeps others", v, 32'h3);
    wr(A_MASK, 32'hFFFF_FFFD);
    rd(A_MASK, v); check("R8 mask write 0 disables", v, 32'h1);
    wr(A_MASK, 32'hFFFF_FFFE);
    check("R9 all masked irq low", {31'b0, irq}, 0);
    wr(A_UNM, 32'h3);

    // R7 clear
    wr(A_CLR, 32'h0);
    rd(A_STAT, v); check("R7 clear zeros no effect", v, 32'h3);
    wr(A_CLR, 32'h1);
    rd(A_STAT, v); check("R7 clear pin0", v, 32'h2);
    wr(A_CLR, 32'h2);
    rd(A_STAT, v); check("R7 clear pin1", v, 32'h0);
    check("R9 irq low after clear", {31'b0, irq}, 0);

    // R5 both edges on pin2 (polarity 0)
    wr(A_BOTH, 32'h4); wr(A_TRIG, 32'h7); wr(A_MODE, 32'h7);
    @(negedge clk); pins = 32'h4; tick(4);
    rd(A_STAT, v); check("R5 rising", v, 32'h4);
    wr(A_CLR, 32'h4);
    @(negedge clk); pins = 32'h0; tick(4);
    rd(A_STAT, v); check("R5 falling", v, 32'h4);
    wr(A_CLR, 32'h4);

    // R6 level low on pin3
    wr(A_POL, 32'hA); wr(A_MODE, 32'hF); tick(1);
    rd(A_STAT, v); check("R6 active low level", v, 32'h8);
    wr(A_CLR, 32'h8);
    rd(A_STAT, v); check("R6 clear ignored", v, 32'h8);
    @(negedge clk); pins = 32'h8;
    @(negedge clk); rd(A_STAT, v); check("R6 one edge still set", v, 32'h8);
    @(negedge clk); rd(A_STAT, v); check("R6 follows pin", v, 32'h0);

    // R10 leaving edge mode drops latch
    @(negedge clk); pins = 32'h9; tick(4);
    rd(A_STAT, v); check("R10 pin0 latched", v, 32'h1);
    wr(A_MODE, 32'hE);
    rd(A_STAT, v); check("R10 io mode status 0", v, 32'h0);
    wr(A_MODE, 32'hF); tick(1);
    rd(A_STAT, v); check("R10 latch discarded", v, 32'h0);

    // R11 unmapped and read-only offsets
    wr(A_FILT, 32'hFFFF_FFFF);
    rd(A_FILT, v); check("R11 0x28 reads 0", v, 0);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); check("R11 0x40 reads 0", v, 0);
    wr(A_DIN, 32'hFFFF_FFFF);
    rd(A_DIN, v); check("R11 din write ignored", v, 32'h9);
    rd(A_DIR, v); check("R11 dir untouched", v, 32'h0000_FFFF);
    rd(A_MASK, v); check("R11 mask untouched", v, 32'h3);

    tick(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule